// File: doc/BRIEF.md
# Tunable Quadrature NCO

This block is a numerically controlled oscillator for a digital phase-locked loop. Each enabled sample it advances a 20-bit phase register (a fraction of one cycle) by a static frequency word plus a scaled-down copy of a signed tuning value. The tuning value comes from an external loop filter, and the block applies the value it captured at the previous enabled sample. The scale factor is a fixed power of two, 2^-12. This makes the largest frequency pull equal to the gain times the sample rate when the tuning value is 1.0.

From the phase it held before each update, the block produces 12-bit signed cosine and sine samples. These come from a quarter-wave table of 256 magnitudes and are folded into all four quadrants by mirroring the table index and negating the result. The quadrature pair feeds a complex phase detector, and the phase register can be read directly as the oscillator's instantaneous phase.

Top module: `tuned_nco`

## Requirements
- R1: While `rst` is high at a clock edge, the phase becomes 0 and the outputs take the phase-zero sample: `cos_o` = 2047 and `sin_o` = 6, which is the table value for index 0.
- R2: On each edge with `smp_en` high, `phase_o` becomes (`phase_o` + `freq_word` + tuning increment) mod 2^20. The phase wraps with no saturation, and a word of 0xFFFFF acts as a step of minus one.
- R3: The tuning increment is the 24-bit two's-complement `tune` shifted arithmetically right by 12 bits, which rounds toward minus infinity. Examples: -1 gives -1, 4095 gives 0, -4097 gives -2, and 2^20 (tuning value 1.0) gives +256 phase LSBs.
- R4: The tuning increment used at an enabled edge comes from the `tune` value captured at the previous enabled edge, which is 0 after reset. The value present at the same edge has no effect until the next enabled edge.
- R5: With `smp_en` low, `phase_o`, `cos_o` and `sin_o` hold their values, and `tune` is not captured.
- R6: At an enabled edge, `cos_o` and `sin_o` are computed from the phase held before that edge's update, so they lag `phase_o` by one sample.
- R7: Let m be the top 10 bits of the source phase. `cos_o` is within 1 LSB of round(2047·cos(2π(m+0.5)/1024)), and `sin_o` is within 1 LSB of the matching sine value. The outputs have 11 fractional bits.
- R8: Quadrant signs follow the top two bits q of the source phase: q=0 gives cos>0 and sin>0; q=1 gives cos<0 and sin>0; q=2 gives both <0; q=3 gives cos>0 and sin<0. Neither output ever takes the value -2048.
- R9: cos_o² + sin_o² stays within 4·2047 of 2047² at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | Sample enable; one phase step per enabled edge |
| freq_word | input | 20 | Nominal phase increment per sample, fraction of a cycle |
| tune | input | 24 | Signed tuning value from the loop filter; 2^20 represents 1.0 |
| phase_o | output | 20 | Current accumulated phase |
| cos_o | output | 12 | Signed cosine sample of the previous phase |
| sin_o | output | 12 | Signed sine sample of the previous phase |

## Verification
- **Fixed frequency words:** small, mid-size and all-ones frequency words with zero tuning run the phase through many wraps. This separates correct modular addition from saturation and sign errors, and it sweeps the table through every quadrant.
- **Single tuning values:** boundary tuning values (-1, 4095, -4096, -4097 and the extremes) are applied one at a time with a zero frequency word. This isolates the floor-rounding shift and the one-sample lag of the captured tuning value.
- **Enable gaps:** gaps with changing inputs confirm that nothing moves or gets captured while disabled.
- **Quadrant step:** a quarter-cycle step from reset tells a one-sample output lag apart from a lookup of the new phase.
- **Random stimulus:** random words, tuning values and enable patterns compare phase, both outputs, quadrant signs and amplitude against a behavioural model on every sample.

// File: rtl/nco_pkg.sv
package nco_pkg;

    // Quarter-wave table address width: 2**LUT_AW magnitudes per quadrant.
    localparam int LUT_AW = 8;

    // pi/2 in Q30 fixed point.
    localparam longint HALF_PI_Q30 = 64'sd1686629713;

    typedef enum logic [1:0] {
        QUAD_I   = 2'd0,
        QUAD_II  = 2'd1,
        QUAD_III = 2'd2,
        QUAD_IV  = 2'd3
    } quadrant_e;

    typedef struct packed {
        logic [LUT_AW-1:0] cos_addr;
        logic [LUT_AW-1:0] sin_addr;
        logic              cos_neg;
        logic              sin_neg;
    } fold_ctrl_t;

    // Rounded amp*sin(pi/2 * (idx+0.5)/2**LUT_AW) by Taylor series in Q30.
    function automatic int quarter_sine(input int idx, input int amp);
        longint x;
        longint x2;
        longint term;
        longint acc;
        x    = (longint'(2 * idx + 1) * HALF_PI_Q30) >>> (LUT_AW + 1);
        x2   = (x * x) >>> 30;
        term = x;
        acc  = x;
        for (int k = 1; k <= 6; k++) begin
            term = -(((term * x2) >>> 30) / longint'((2 * k) * (2 * k + 1)));
            acc  = acc + term;
        end
        return int'((acc * longint'(amp) + (64'sd1 <<< 29)) >>> 30);
    endfunction

    // Map a quadrant and in-quadrant index onto table reads and signs.
    function automatic fold_ctrl_t fold_decode(input quadrant_e quad,
                                               input logic [LUT_AW-1:0] idx);
        fold_ctrl_t f;
        case (quad)
            QUAD_I: begin
                f.cos_addr = ~idx; f.cos_neg = 1'b0;
                f.sin_addr = idx;  f.sin_neg = 1'b0;
            end
            QUAD_II: begin
                f.cos_addr = idx;  f.cos_neg = 1'b1;
                f.sin_addr = ~idx; f.sin_neg = 1'b0;
            end
            QUAD_III: begin
                f.cos_addr = ~idx; f.cos_neg = 1'b1;
                f.sin_addr = idx;  f.sin_neg = 1'b1;
            end
            default: begin
                f.cos_addr = idx;  f.cos_neg = 1'b0;
                f.sin_addr = ~idx; f.sin_neg = 1'b1;
            end
        endcase
        return f;
    endfunction

endpackage

// File: rtl/nco_phase_accum.sv
module nco_phase_accum
    import nco_pkg::*;
#(
    parameter int PHASE_W    = 20,
    parameter int TUNE_W     = 24,
    parameter int GAIN_SHIFT = 12
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      smp_en,
    input  logic [PHASE_W-1:0]        freq_word,
    input  logic signed [TUNE_W-1:0]  tune,
    output logic [PHASE_W-1:0]        phase,
    output logic signed [TUNE_W-1:0]  tune_held
);

    localparam int SCALED_W = TUNE_W - GAIN_SHIFT;

    logic signed [TUNE_W-1:0]   tune_q;
    logic [PHASE_W-1:0]         phase_q;
    logic signed [SCALED_W-1:0] tune_scaled;
    logic [PHASE_W-1:0]         tune_inc;
    logic [PHASE_W-1:0]         phase_next;

    // Power-of-two loop gain: arithmetic right shift, floor rounding.
    generate
        if (GAIN_SHIFT == 0) begin : g_unity_gain
            assign tune_scaled = tune_q;
        end else begin : g_shift_gain
            assign tune_scaled = SCALED_W'(tune_q >>> GAIN_SHIFT);
        end
    endgenerate

    assign tune_inc   = PHASE_W'(tune_scaled);
    assign phase_next = phase_q + freq_word + tune_inc;

    always_ff @(posedge clk) begin
        if (rst) begin
            tune_q  <= '0;
            phase_q <= '0;
        end else if (smp_en) begin
            tune_q  <= tune;
            phase_q <= phase_next;
        end
    end

    assign phase     = phase_q;
    assign tune_held = tune_q;

endmodule

// File: rtl/nco_quarter_rom.sv
module nco_quarter_rom
    import nco_pkg::*;
#(
    parameter int VAL_W = 11,
    parameter int AMP   = 2047
) (
    input  logic [LUT_AW-1:0] addr_a,
    input  logic [LUT_AW-1:0] addr_b,
    output logic [VAL_W-1:0]  data_a,
    output logic [VAL_W-1:0]  data_b
);

    localparam int DEPTH = 1 << LUT_AW;

    logic [VAL_W-1:0] table_w [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_entry
            localparam int ENTRY = quarter_sine(i, AMP);
            assign table_w[i] = VAL_W'(ENTRY);
        end
    endgenerate

    assign data_a = table_w[addr_a];
    assign data_b = table_w[addr_b];

endmodule

// File: rtl/nco_fold.sv
module nco_fold
    import nco_pkg::*;
#(
    parameter int OUT_W = 12
) (
    input  logic [LUT_AW+1:0]        phase_top,
    output logic [LUT_AW-1:0]        cos_addr,
    output logic [LUT_AW-1:0]        sin_addr,
    input  logic [OUT_W-2:0]         cos_mag,
    input  logic [OUT_W-2:0]         sin_mag,
    output logic signed [OUT_W-1:0]  cos_val,
    output logic signed [OUT_W-1:0]  sin_val
);

    fold_ctrl_t ctrl;
    quadrant_e  quad;

    assign quad     = quadrant_e'(phase_top[LUT_AW+1:LUT_AW]);
    assign ctrl     = fold_decode(quad, phase_top[LUT_AW-1:0]);
    assign cos_addr = ctrl.cos_addr;
    assign sin_addr = ctrl.sin_addr;

    always_comb begin
        cos_val = signed'({1'b0, cos_mag});
        sin_val = signed'({1'b0, sin_mag});
        if (ctrl.cos_neg) cos_val = -cos_val;
        if (ctrl.sin_neg) sin_val = -sin_val;
    end

endmodule

// File: rtl/tuned_nco.sv
module tuned_nco
    import nco_pkg::*;
#(
    parameter int PHASE_W    = 20,
    parameter int OUT_W      = 12,
    parameter int TUNE_W     = 24,
    parameter int GAIN_SHIFT = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     smp_en,
    input  logic [PHASE_W-1:0]       freq_word,
    input  logic signed [TUNE_W-1:0] tune,
    output logic [PHASE_W-1:0]       phase_o,
    output logic signed [OUT_W-1:0]  cos_o,
    output logic signed [OUT_W-1:0]  sin_o
);

    localparam int AMP = (1 << (OUT_W - 1)) - 1;
    localparam int TOP_W = LUT_AW + 2;
    localparam logic signed [OUT_W-1:0] RST_COS =
        OUT_W'(quarter_sine((1 << LUT_AW) - 1, AMP));
    localparam logic signed [OUT_W-1:0] RST_SIN =
        OUT_W'(quarter_sine(0, AMP));

    logic [PHASE_W-1:0]       phase;
    logic signed [TUNE_W-1:0] tune_held;
    logic [LUT_AW-1:0]        cos_addr;
    logic [LUT_AW-1:0]        sin_addr;
    logic [OUT_W-2:0]         cos_mag;
    logic [OUT_W-2:0]         sin_mag;
    logic signed [OUT_W-1:0]  cos_val;
    logic signed [OUT_W-1:0]  sin_val;
    logic signed [OUT_W-1:0]  cos_q;
    logic signed [OUT_W-1:0]  sin_q;

    nco_phase_accum #(
        .PHASE_W    (PHASE_W),
        .TUNE_W     (TUNE_W),
        .GAIN_SHIFT (GAIN_SHIFT)
    ) u_accum (
        .clk       (clk),
        .rst       (rst),
        .smp_en    (smp_en),
        .freq_word (freq_word),
        .tune      (tune),
        .phase     (phase),
        .tune_held (tune_held)
    );

    nco_fold #(
        .OUT_W (OUT_W)
    ) u_fold (
        .phase_top (phase[PHASE_W-1 -: TOP_W]),
        .cos_addr  (cos_addr),
        .sin_addr  (sin_addr),
        .cos_mag   (cos_mag),
        .sin_mag   (sin_mag),
        .cos_val   (cos_val),
        .sin_val   (sin_val)
    );

    nco_quarter_rom #(
        .VAL_W (OUT_W - 1),
        .AMP   (AMP)
    ) u_rom (
        .addr_a (cos_addr),
        .addr_b (sin_addr),
        .data_a (cos_mag),
        .data_b (sin_mag)
    );

    // Outputs register the lookup of the phase held before the update.
    always_ff @(posedge clk) begin
        if (rst) begin
            cos_q <= RST_COS;
            sin_q <= RST_SIN;
        end else if (smp_en) begin
            cos_q <= cos_val;
            sin_q <= sin_val;
        end
    end

    assign phase_o = phase;
    assign cos_o   = cos_q;
    assign sin_o   = sin_q;

endmodule

// File: rtl/nco_checker.sv
module nco_checker #(
    parameter int PHASE_W    = 20,
    parameter int OUT_W      = 12,
    parameter int TUNE_W     = 24,
    parameter int GAIN_SHIFT = 12
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     smp_en,
    input logic [PHASE_W-1:0]       freq_word,
    input logic signed [TUNE_W-1:0] tune,
    input logic signed [TUNE_W-1:0] tune_held,
    input logic [PHASE_W-1:0]       phase_o,
    input logic signed [OUT_W-1:0]  cos_o,
    input logic signed [OUT_W-1:0]  sin_o
);

    localparam int AMP    = (1 << (OUT_W - 1)) - 1;
    localparam int MAG_LO = AMP * AMP - 4 * AMP;
    localparam int MAG_HI = AMP * AMP + 4 * AMP;

    int c_i;
    int s_i;
    int mag;
    logic [PHASE_W-1:0] inc_from_held;

    assign c_i = int'(cos_o);
    assign s_i = int'(sin_o);
    assign mag = c_i * c_i + s_i * s_i;
    assign inc_from_held = PHASE_W'(tune_held >>> GAIN_SHIFT);

    // R1: reset clears the phase
    assert_reset_phase_R1: assert property (@(posedge clk)
        $past(rst) |-> phase_o == '0);

    // R2, R3: phase step uses word plus shifted held tuning value
    assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
        smp_en |=> phase_o == PHASE_W'($past(phase_o) + $past(freq_word)
                                        + $past(inc_from_held)));

    // R4: tuning value captured on each enabled edge
    assert_tune_lag_R4: assert property (@(posedge clk) disable iff (rst)
        smp_en |=> tune_held == $past(tune));

    // R5: disabled edges change nothing
    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !smp_en |=> $stable(phase_o) && $stable(cos_o) && $stable(sin_o)
                    && $stable(tune_held));

    // R6, R8: outputs follow the quadrant of the pre-update phase
    assert_quad_first_R8: assert property (@(posedge clk) disable iff (rst)
        smp_en && phase_o[PHASE_W-1 -: 2] == 2'd0 |=> c_i > 0 && s_i > 0);

    assert_quad_third_R8: assert property (@(posedge clk) disable iff (rst)
        smp_en && phase_o[PHASE_W-1 -: 2] == 2'd2 |=> c_i < 0 && s_i < 0);

    assert_no_neg_full_R8: assert property (@(posedge clk) disable iff (rst)
        c_i != -(AMP + 1) && s_i != -(AMP + 1));

    // R9: quadrature pair keeps constant amplitude
    assert_amplitude_R9: assert property (@(posedge clk) disable iff (rst)
        mag >= MAG_LO && mag <= MAG_HI);

endmodule

bind tuned_nco nco_checker #(
    .PHASE_W    (PHASE_W),
    .OUT_W      (OUT_W),
    .TUNE_W     (TUNE_W),
    .GAIN_SHIFT (GAIN_SHIFT)
) u_nco_checker (
    .clk       (clk),
    .rst       (rst),
    .smp_en    (smp_en),
    .freq_word (freq_word),
    .tune      (tune),
    .tune_held (tune_held),
    .phase_o   (phase_o),
    .cos_o     (cos_o),
    .sin_o     (sin_o)
);

// File: tb/tuned_nco_bench.sv
module tuned_nco_bench;

    localparam int PW   = 20;
    localparam int OW   = 12;
    localparam int TW   = 24;
    localparam int GS   = 12;
    localparam int MASK = (1 << PW) - 1;
    localparam int AMP  = 2047;
    localparam real TWO_PI = 6.283185307179586;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 smp_en = 1'b0;
    logic [PW-1:0]        freq_word = '0;
    logic signed [TW-1:0] tune = '0;
    logic [PW-1:0]        phase_o;
    logic signed [OW-1:0] cos_o;
    logic signed [OW-1:0] sin_o;

    tuned_nco u_tuned_nco (
        .clk       (clk),
        .rst       (rst),
        .smp_en    (smp_en),
        .freq_word (freq_word),
        .tune      (tune),
        .phase_o   (phase_o),
        .cos_o     (cos_o),
        .sin_o     (sin_o)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural model state
    int m_phase;
    int m_tune_prev;
    int m_src;

    function automatic int ideal(input int ph, input bit want_sin);
        real ang;
        real v;
        ang = TWO_PI * (real'(ph >> 10) + 0.5) / 1024.0;
        v = want_sin ? $sin(ang) : $cos(ang);
        return int'($floor(real'(AMP) * v + 0.5));
    endfunction

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_near(input string tag, input int act, input int exp);
        checks++;
        if (act > exp + 1 || act < exp - 1) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (+/-1)", tag, act, exp);
        end
    endtask

    task automatic check_outputs(input string tag);
        int c;
        int s;
        int q;
        int mag;
        bit ok;
        c = int'(cos_o);
        s = int'(sin_o);
        check_eq(tag, int'(phase_o), m_phase);
        check_near("R7 cos", c, ideal(m_src, 1'b0));
        check_near("R7 sin", s, ideal(m_src, 1'b1));
        q = (m_src >> (PW - 2)) & 3;
        case (q)
            0: ok = c > 0 && s > 0;
            1: ok = c < 0 && s > 0;
            2: ok = c < 0 && s < 0;
            default: ok = c > 0 && s < 0;
        endcase
        ok = ok && c != -2048 && s != -2048;
        check_eq("R8 quadrant signs", int'(ok), 1);
        mag = c * c + s * s;
        check_eq("R9 amplitude", int'(mag >= AMP * AMP - 4 * AMP && mag <= AMP * AMP + 4 * AMP), 1);
    endtask

    // Drive at a falling edge, update model at the rising edge, compare at the next falling edge.
    task automatic step(input bit en, input int fw, input int tn, input string tag);
        freq_word = PW'(fw);
        tune      = TW'(tn);
        smp_en    = en;
        @(posedge clk);
        if (en) begin
            m_src       = m_phase;
            m_phase     = (m_phase + fw + (m_tune_prev >>> GS)) & MASK;
            m_tune_prev = tn;
        end
        @(negedge clk);
        check_outputs(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        smp_en = 1'b0;
        @(posedge clk);
        @(posedge clk);
        m_phase = 0;
        m_tune_prev = 0;
        m_src = 0;
        @(negedge clk);
        rst = 1'b0;
        check_eq("R1 reset phase", int'(phase_o), 0);
        check_eq("R1 reset cos", int'(cos_o), 2047);
        check_near("R1 reset sin", int'(sin_o), 6);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int held_phase;
        int held_cos;
        @(negedge clk);
        do_reset();

        // R6: quarter-cycle step; outputs still show phase 0
        step(1'b1, 32'h40000, 0, "R2 quarter step");
        check_eq("R6 cos lags phase", int'(cos_o), 2047);
        step(1'b1, 32'h40000, 0, "R2 quarter step");
        check_near("R6 cos of previous phase", int'(cos_o), ideal(32'h40000, 1'b0));

        // R2: steady word with many wraps
        for (int i = 0; i < 300; i++) step(1'b1, 32'h0ABCD, 0, "R2 steady word");
        // R2: all-ones word is a step of minus one
        for (int i = 0; i < 20; i++) step(1'b1, 32'hFFFFF, 0, "R2 all-ones word");

        // R3: floor shift of tuning values, each applied then flushed with zero
        do_reset();
        begin
            int vals [7] = '{4096, -1, -4096, 4095, -4097, 8388607, -8388608};
            foreach (vals[k]) begin
                step(1'b1, 0, vals[k], "R3 tune capture");
                step(1'b1, 0, 0, "R3 tune shift");
            end
        end
        check_eq("R3 net phase", int'(phase_o), (1 - 1 - 1 + 0 - 2 + 2047 - 2048) & MASK);

        // R4: new tuning value has no effect on the same edge
        do_reset();
        step(1'b1, 0, 1 << 20, "R4 same-edge");
        check_eq("R4 same-edge no effect", int'(phase_o), 0);
        step(1'b1, 0, 0, "R4 next-edge");
        check_eq("R4 applied next edge", int'(phase_o), 256);

        // R5: gaps with changing inputs
        step(1'b1, 32'h12345, 3 << 16, "R5 before gap");
        held_phase = int'(phase_o);
        held_cos = int'(cos_o);
        for (int i = 0; i < 6; i++) step(1'b0, 32'h7FFFF - i, -(i << 14), "R5 gap");
        check_eq("R5 phase held", int'(phase_o), held_phase);
        check_eq("R5 cos held", int'(cos_o), held_cos);
        step(1'b1, 32'h00100, 0, "R5 after gap uses pre-gap tune");

        // Random mix compared every sample
        for (int i = 0; i < 2000; i++) begin
            int fw;
            int tn;
            bit en;
            fw = int'($urandom_range(0, MASK));
            tn = int'($urandom_range(0, (1 << 22))) - (1 << 21);
            en = ($urandom_range(0, 3) != 0);
            step(en, fw, tn, en ? "R2 random" : "R5 random gap");
        end

        // R1: reset in mid-run
        do_reset();
        step(1'b1, 32'h00400, 0, "R2 after reset");

        finish_run();
    end

endmodule